// File: doc/BRIEF.md
# Graphics DRAM Command Sequencer

This block sits on the controller side of a two-bank synchronous graphics memory and owns its command pins. The pins are chip select, row strobe, column strobe, write enable, the special-function select, clock enable, and an 11-bit address. After reset it runs the power-up sequence without help. It waits with NOP on the pins, precharges both banks, refreshes the array a fixed number of times, and then loads the mode register. After that it keeps the array refreshed on a fixed interval.

Once initialization is over, a client issues one request at a time: activate, read, write or precharge. The client holds `req_valid` and waits for `req_ready`. The sequencer accepts a request only when the bank state and the timing counters allow it. The accepted command then appears on the pins in the next cycle.

All memory timings are parameters in clock cycles. A refresh that comes due wins over client requests. If any bank is open at that point, the sequencer closes both banks with a precharge-all before the refresh.

Top module: `sgram_seq`

## Requirements
- R1: While reset is held, and for at least T_PWRUP cycles after it is released, the pins show NOP with clock enable high and all four byte masks high; `init_done` stays low.
- R2: Initialization issues, in this order: a precharge-all with A9 high, then exactly N_INIT_REF refreshes, then one mode register load. The first refresh comes at least T_RP cycles after the precharge, and the refreshes are at least T_RC cycles apart. Until `init_done` rises, only NOP, precharge and refresh appear, and the byte masks drop to 0 once it is high.
- R3: The command pins {cs_n, ras_n, cas_n, we_n, dsf} carry these codes: NOP 01110, activate 00110, read 01010, write 01000, precharge 00100, refresh 00010, mode load 00000. Clock enable is always high.
- R4: The mode load puts {A10..A7 = 0000, A6..A4 = CL_CODE, A3 = BT, A2..A0 = BL_CODE} on the address. No other command follows within T_MRD cycles after it.
- R5: A refresh is due T_REFI cycles after the mode load and then every T_REFI cycles. If a bank is open when it is due, a precharge-all (A9 high) comes first, and the refresh follows exactly T_RP cycles later. Afterwards both banks are closed, so a read to a previously open bank is no longer accepted.
- R6: After any refresh, the next command comes no earlier than T_RC cycles later.
- R7: An activate drives A10 = bank and A9..A0 = row. It is accepted only for a closed bank, at least T_RP cycles after that bank was precharged, and at least T_RRD cycles after the previous activate. An activate to an open bank is never accepted.
- R8: A read or write drives A10 = bank, A9 = auto-precharge flag, A8 = 0 and A7..A0 = column. It is accepted only for an open bank, no earlier than T_RCD cycles after that bank's activate. A read or write to a closed bank is never accepted.
- R9: A precharge drives A10 = bank and A9 = all-banks flag; with A9 high both banks close. A read or write with auto-precharge closes its bank, and the next activate to that bank comes T_AP cycles later.
- R10: `req_ready` is high only while `init_done` is high. It is high for the one cycle in which the request is taken, and the command is on the pins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Client request present |
| req_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| req_bank | input | 1 | Target bank |
| req_addr | input | 10 | Row (activate) or column in bits 7..0 (read/write) |
| req_ap | input | 1 | Auto-precharge (read/write) or all banks (precharge) |
| req_ready | output | 1 | Request taken this cycle |
| init_done | output | 1 | Initialization finished |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select, low active |
| mem_ras_n | output | 1 | Row strobe, low active |
| mem_cas_n | output | 1 | Column strobe, low active |
| mem_we_n | output | 1 | Write enable, low active |
| mem_dsf | output | 1 | Special-function select |
| mem_addr | output | 11 | Address; A10 bank, A9 precharge option |
| mem_dqm | output | 4 | Byte masks |

## Verification
The embedded checks assume that the client changes `req_op`, `req_bank`, `req_addr` and `req_ap` only while `req_valid` is low or in the cycle after a handshake. They also assume that T_PWRUP, T_RP, T_RC, T_RCD, T_RRD and T_AP are all at least 1. The bench drives each request on the falling edge, holds it until `req_ready` is seen, and drops it right after the accepting edge. It also runs its directed client traffic well before the first refresh comes due, so no refresh closes a bank in the middle of a sequence. The final scenario then deliberately leaves a bank open across two refreshes.

// File: rtl/sgram_seq.sv
module sgram_seq #(
  parameter int T_PWRUP    = 50000,
  parameter int T_RP       = 3,
  parameter int T_RCD      = 3,
  parameter int T_RRD      = 2,
  parameter int T_RC       = 9,
  parameter int T_MRD      = 2,
  parameter int T_AP       = 8,
  parameter int N_INIT_REF = 8,
  parameter int T_REFI     = 1562,
  parameter logic [2:0] BL_CODE = 3'b010,
  parameter logic       BT      = 1'b0,
  parameter logic [2:0] CL_CODE = 3'b011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic        req_bank,
  input  logic [9:0]  req_addr,
  input  logic        req_ap,
  output logic        req_ready,
  output logic        init_done,
  output logic        mem_cke,
  output logic        mem_cs_n,
  output logic        mem_ras_n,
  output logic        mem_cas_n,
  output logic        mem_we_n,
  output logic        mem_dsf,
  output logic [10:0] mem_addr,
  output logic [3:0]  mem_dqm
);

  localparam int GW = $clog2(T_PWRUP + T_RC + T_RP + T_MRD + 2);
  localparam int BW = $clog2(T_RP + T_AP + T_RCD + T_RRD + 2);
  localparam int RW = $clog2(T_REFI + 1);
  localparam int NW = $clog2(N_INIT_REF + 1);

  localparam logic [4:0] C_NOP = 5'b01110;
  localparam logic [4:0] C_ACT = 5'b00110;
  localparam logic [4:0] C_RD  = 5'b01010;
  localparam logic [4:0] C_WR  = 5'b01000;
  localparam logic [4:0] C_PRE = 5'b00100;
  localparam logic [4:0] C_REF = 5'b00010;
  localparam logic [4:0] C_MRS = 5'b00000;

  localparam logic [10:0] MODE_WORD = {4'b0000, CL_CODE, BT, BL_CODE};

  typedef enum logic [1:0] {S_PWR, S_IREF, S_MRS, S_RUN} st_t;

  st_t                  st;
  logic [GW-1:0]        gap;
  logic [NW-1:0]        nref;
  logic [RW-1:0]        rtmr;
  logic                 due;
  logic [1:0]           open_b;
  logic [1:0][BW-1:0]   rp_c;
  logic [1:0][BW-1:0]   rcd_c;
  logic [BW-1:0]        rrd_c;
  logic [4:0]           cmd_q;
  logic [10:0]          addr_q;
  logic                 done_q;
  logic                 ok;

  always_comb begin
    case (req_op)
      2'd0:    ok = !open_b[req_bank] && rp_c[req_bank] == '0 && rrd_c == '0;
      2'd1,
      2'd2:    ok = open_b[req_bank] && rcd_c[req_bank] == '0;
      default: ok = 1'b1;
    endcase
  end

  assign req_ready = (st == S_RUN) && gap == '0 && !due && req_valid && ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_PWR;
      gap    <= GW'(T_PWRUP - 1);
      nref   <= '0;
      rtmr   <= '0;
      due    <= 1'b0;
      open_b <= '0;
      rp_c   <= '0;
      rcd_c  <= '0;
      rrd_c  <= '0;
      cmd_q  <= C_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= C_NOP;
      addr_q <= '0;
      if (gap != '0) gap <= gap - 1'b1;
      if (rrd_c != '0) rrd_c <= rrd_c - 1'b1;
      for (int i = 0; i < 2; i++) begin
        if (rp_c[i] != '0)  rp_c[i]  <= rp_c[i] - 1'b1;
        if (rcd_c[i] != '0) rcd_c[i] <= rcd_c[i] - 1'b1;
      end

      if (gap == '0) begin
        case (st)
          S_PWR: begin
            cmd_q  <= C_PRE;
            addr_q <= 11'b010_0000_0000;
            gap    <= GW'(T_RP - 1);
            st     <= S_IREF;
          end
          S_IREF: begin
            cmd_q <= C_REF;
            gap   <= GW'(T_RC - 1);
            nref  <= nref + 1'b1;
            if (nref == NW'(N_INIT_REF - 1)) st <= S_MRS;
          end
          S_MRS: begin
            cmd_q  <= C_MRS;
            addr_q <= MODE_WORD;
            gap    <= GW'(T_MRD);
            st     <= S_RUN;
            done_q <= 1'b1;
          end
          default: begin
            if (due) begin
              if (|open_b) begin
                cmd_q  <= C_PRE;
                addr_q <= 11'b010_0000_0000;
                open_b <= '0;
                rp_c   <= {BW'(T_RP - 1), BW'(T_RP - 1)};
                gap    <= GW'(T_RP - 1);
              end else begin
                cmd_q <= C_REF;
                gap   <= GW'(T_RC - 1);
                due   <= 1'b0;
              end
            end else if (req_ready) begin
              case (req_op)
                2'd0: begin
                  cmd_q            <= C_ACT;
                  addr_q           <= {req_bank, req_addr};
                  open_b[req_bank] <= 1'b1;
                  rcd_c[req_bank]  <= BW'(T_RCD - 1);
                  rrd_c            <= BW'(T_RRD - 1);
                end
                2'd1, 2'd2: begin
                  cmd_q  <= (req_op == 2'd1) ? C_RD : C_WR;
                  addr_q <= {req_bank, req_ap, 1'b0, req_addr[7:0]};
                  if (req_ap) begin
                    open_b[req_bank] <= 1'b0;
                    rp_c[req_bank]   <= BW'(T_AP - 1);
                  end
                end
                default: begin
                  cmd_q  <= C_PRE;
                  addr_q <= {req_bank, req_ap, 9'b0};
                  if (req_ap) begin
                    open_b <= '0;
                    rp_c   <= {BW'(T_RP - 1), BW'(T_RP - 1)};
                  end else begin
                    open_b[req_bank] <= 1'b0;
                    rp_c[req_bank]   <= BW'(T_RP - 1);
                  end
                end
              endcase
            end
          end
        endcase
      end

      if (st == S_RUN) begin
        if (rtmr == RW'(T_REFI - 1)) begin
          rtmr <= '0;
          due  <= 1'b1;
        end else begin
          rtmr <= rtmr + 1'b1;
        end
      end
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dsf} = cmd_q;
  assign mem_addr  = addr_q;
  assign mem_cke   = 1'b1;
  assign mem_dqm   = {4{~done_q}};
  assign init_done = done_q;

  logic [GW-1:0] rc_cnt;
  logic [BW-1:0] act_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_cnt  <= GW'(T_RC);
      act_cnt <= BW'(T_RRD);
    end else begin
      if (cmd_q == C_REF) rc_cnt <= GW'(1);
      else if (rc_cnt < GW'(T_RC)) rc_cnt <= rc_cnt + 1'b1;
      if (cmd_q == C_ACT) act_cnt <= BW'(1);
      else if (act_cnt < BW'(T_RRD)) act_cnt <= act_cnt + 1'b1;
    end
  end

  AST_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP) |-> (rc_cnt >= GW'(T_RC))); // R6
  AST_REF_BANKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF) |-> (open_b == 2'b00)); // R5
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT) |-> (act_cnt >= BW'(T_RRD))); // R7
  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done); // R10
  AST_ACK_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (cmd_q != C_NOP)); // R10
  AST_INIT_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (cmd_q == C_NOP || cmd_q == C_PRE || cmd_q == C_REF)); // R2
  AST_MASKS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (mem_dqm == 4'hF)); // R1

endmodule

// File: tb/sgram_seq_test.sv
`timescale 1ns/1ps
module sgram_seq_test;
  localparam int T_PWRUP = 20, T_RP = 3, T_RCD = 3, T_RRD = 2, T_RC = 6;
  localparam int T_MRD = 2, T_AP = 7, N_REF = 8, T_REFI = 1000;
  localparam logic [10:0] MODE = 11'h032;
  localparam logic [4:0] NOP = 5'b01110, ACT = 5'b00110, RD = 5'b01010, WR = 5'b01000;
  localparam logic [4:0] PRE = 5'b00100, REF = 5'b00010, MRS = 5'b00000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_bank = 0, req_ap = 0;
  logic [1:0] req_op = 0;
  logic [9:0] req_addr = 0;
  logic req_ready, init_done, mem_cke, cs_n, ras_n, cas_n, we_n, dsf;
  logic [10:0] mem_addr;
  logic [3:0] mem_dqm;
  wire [4:0] cmd = {cs_n, ras_n, cas_n, we_n, dsf};

  sgram_seq #(.T_PWRUP(T_PWRUP), .T_RP(T_RP), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RC(T_RC),
    .T_MRD(T_MRD), .T_AP(T_AP), .N_INIT_REF(N_REF), .T_REFI(T_REFI),
    .BL_CODE(3'b010), .BT(1'b0), .CL_CODE(3'b011)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank),
    .req_addr(req_addr), .req_ap(req_ap), .req_ready(req_ready), .init_done(init_done),
    .mem_cke(mem_cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n),
    .mem_we_n(we_n), .mem_dsf(dsf), .mem_addr(mem_addr), .mem_dqm(mem_dqm));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, n_log = 0, rel = 0;
  int l_cyc [512];
  logic [4:0] l_cmd [512];
  logic [10:0] l_adr [512];
  bit early_ack = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && cmd !== NOP && n_log < 512) begin
      l_cyc[n_log] = cyc; l_cmd[n_log] = cmd; l_adr[n_log] = mem_addr; n_log = n_log + 1;
    end
    if (req_ready && !init_done) early_ack = 1;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    summary();
  end

  task automatic do_req(input logic [1:0] op, input logic b, input logic [9:0] a,
                        input logic ap, input int maxw, output bit acked);
    acked = 0;
    req_op = op; req_bank = b; req_addr = a; req_ap = ap; req_valid = 1;
    for (int i = 0; i < maxw; i++) begin
      #0.5;
      if (req_ready) begin acked = 1; @(negedge clk); break; end
      @(negedge clk);
    end
    req_valid = 0;
    #0.5;
  endtask

  task automatic t_reset;
    bit bad;
    req_valid = 1; req_op = 0; req_bank = 0; req_addr = 10'h3;
    repeat (4) @(negedge clk);
    #0.5;
    chk(cmd == NOP, "R1 cmd in reset", cmd, NOP);
    chk(mem_cke == 1 && mem_dqm == 4'hF, "R1 cke/dqm in reset", {mem_cke, mem_dqm}, 5'h1F);
    chk(!init_done && !req_ready, "R10 no ack in reset", req_ready, 0);
    @(negedge clk); rst_n = 1; rel = cyc;
    bad = 0;
    for (int i = 0; i < T_PWRUP - 1; i++) begin
      @(negedge clk); #0.5;
      if (cmd != NOP || mem_dqm != 4'hF || !mem_cke || init_done) bad = 1;
    end
    chk(!bad, "R1 NOP hold after reset", bad, 0);
    while (n_log == 0) @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_init;
    int w = 0;
    bit ord = 1, sp = 1;
    while (!init_done && w < 1000) begin @(negedge clk); w++; end
    repeat (2) @(negedge clk); #0.5;
    chk(l_cyc[0] - rel >= T_PWRUP - 1, "R1 power-up wait", l_cyc[0] - rel, T_PWRUP);
    chk(l_cmd[0] == PRE && l_adr[0][9], "R2 first is precharge-all", {l_cmd[0], l_adr[0][9]}, {PRE, 1'b1});
    for (int i = 1; i <= N_REF; i++) begin
      if (l_cmd[i] != REF) ord = 0;
      if (i > 1 && l_cyc[i] - l_cyc[i-1] < T_RC) sp = 0;
    end
    chk(ord, "R2 refresh count/order", ord, 1);
    chk(sp, "R2 refresh spacing", sp, 1);
    chk(l_cyc[1] - l_cyc[0] >= T_RP, "R2 precharge to refresh", l_cyc[1] - l_cyc[0], T_RP);
    chk(l_cmd[N_REF+1] == MRS, "R3 mode load code", l_cmd[N_REF+1], MRS);
    chk(l_adr[N_REF+1] == MODE, "R4 mode word", l_adr[N_REF+1], MODE);
    chk(n_log == N_REF + 2, "R2 init command count", n_log, N_REF + 2);
    chk(mem_dqm == 4'h0 && mem_cke, "R2 masks low after init", mem_dqm, 0);
    chk(!early_ack, "R10 no ack before init_done", early_ack, 0);
  endtask

  int i_mrs, i_a0, i_a1, i_rd, i_wr, i_a1b, i_pa, i_a0b;

  task automatic t_bank_ops;
    bit k;
    i_mrs = N_REF + 1;
    do_req(2'd0, 1'b0, 10'h2A5, 1'b0, 20, k); i_a0 = n_log - 1;
    chk(k && l_cmd[i_a0] == ACT, "R3 activate code", l_cmd[i_a0], ACT);
    chk(l_adr[i_a0] == 11'h2A5, "R7 activate address", l_adr[i_a0], 11'h2A5);
    chk(l_cyc[i_a0] - l_cyc[i_mrs] >= T_MRD + 1, "R4 quiet after mode load",
        l_cyc[i_a0] - l_cyc[i_mrs], T_MRD + 1);
    do_req(2'd0, 1'b1, 10'h011, 1'b0, 20, k); i_a1 = n_log - 1;
    chk(l_cyc[i_a1] - l_cyc[i_a0] == T_RRD, "R7 activate spacing", l_cyc[i_a1] - l_cyc[i_a0], T_RRD);
    chk(l_adr[i_a1] == 11'h411, "R7 activate bank1 address", l_adr[i_a1], 11'h411);
    do_req(2'd1, 1'b0, 10'h05C, 1'b0, 20, k); i_rd = n_log - 1;
    chk(l_cmd[i_rd] == RD, "R3 read code", l_cmd[i_rd], RD);
    chk(l_adr[i_rd] == 11'h05C, "R8 read address", l_adr[i_rd], 11'h05C);
    chk(l_cyc[i_rd] - l_cyc[i_a0] == T_RCD, "R8 activate to read", l_cyc[i_rd] - l_cyc[i_a0], T_RCD);
    do_req(2'd2, 1'b1, 10'h30F, 1'b1, 20, k); i_wr = n_log - 1;
    chk(l_cmd[i_wr] == WR, "R3 write code", l_cmd[i_wr], WR);
    chk(l_adr[i_wr] == 11'h60F, "R8 write with auto-precharge address", l_adr[i_wr], 11'h60F);
    do_req(2'd0, 1'b1, 10'h011, 1'b0, 30, k); i_a1b = n_log - 1;
    chk(l_cyc[i_a1b] - l_cyc[i_wr] == T_AP, "R9 auto-precharge to activate",
        l_cyc[i_a1b] - l_cyc[i_wr], T_AP);
    do_req(2'd3, 1'b0, 10'h0, 1'b1, 20, k); i_pa = n_log - 1;
    chk(l_cmd[i_pa] == PRE && l_adr[i_pa] == 11'h200, "R9 precharge-all encoding",
        {l_cmd[i_pa], l_adr[i_pa]}, {PRE, 11'h200});
    do_req(2'd0, 1'b0, 10'h0AA, 1'b0, 20, k); i_a0b = n_log - 1;
    chk(l_cyc[i_a0b] - l_cyc[i_pa] == T_RP, "R7 precharge to activate", l_cyc[i_a0b] - l_cyc[i_pa], T_RP);
  endtask

  task automatic t_illegal;
    bit k;
    int n0 = n_log;
    do_req(2'd1, 1'b1, 10'h012, 1'b0, 12, k);
    chk(!k, "R8 read to closed bank held", k, 0);
    do_req(2'd0, 1'b0, 10'h001, 1'b0, 12, k);
    chk(!k, "R7 activate to open bank held", k, 0);
    chk(n_log == n0, "R8 nothing issued for held requests", n_log - n0, 0);
  endtask

  task automatic t_refresh;
    int w = 0, ir = -1, ir2 = -1, ia;
    bit k;
    while (ir < 0 && w < 2000) begin
      @(negedge clk); #0.5; w++;
      for (int i = i_a0b + 1; i < n_log; i++) if (l_cmd[i] == REF && ir < 0) ir = i;
    end
    chk(ir > 0, "R5 refresh issued", ir, 1);
    if (ir > 0) begin
      chk(l_cmd[ir-1] == PRE && l_adr[ir-1][9], "R5 precharge-all before refresh",
          l_cmd[ir-1], PRE);
      chk(l_cyc[ir] - l_cyc[ir-1] == T_RP, "R5 precharge to refresh", l_cyc[ir] - l_cyc[ir-1], T_RP);
      chk(l_cyc[ir] - l_cyc[i_mrs] >= T_REFI && l_cyc[ir] - l_cyc[i_mrs] <= T_REFI + T_RP + 2,
          "R5 first interval", l_cyc[ir] - l_cyc[i_mrs], T_REFI);
      do_req(2'd1, 1'b0, 10'h001, 1'b0, 10, k);
      chk(!k, "R5 bank closed by refresh", k, 0);
      do_req(2'd0, 1'b0, 10'h0C3, 1'b0, 20, k); ia = n_log - 1;
      chk(k && l_cyc[ia] - l_cyc[ir] >= T_RC, "R6 refresh to activate", l_cyc[ia] - l_cyc[ir], T_RC);
      w = 0;
      while (ir2 < 0 && w < 2000) begin
        @(negedge clk); #0.5; w++;
        for (int i = ia + 1; i < n_log; i++) if (l_cmd[i] == REF && ir2 < 0) ir2 = i;
      end
      chk(ir2 > 0 && l_cyc[ir2] - l_cyc[ir] == T_REFI, "R5 refresh period",
          ir2 > 0 ? l_cyc[ir2] - l_cyc[ir] : -1, T_REFI);
    end
  endtask

  initial begin
    t_reset();
    t_init();
    t_bank_ops();
    t_illegal();
    t_refresh();
    summary();
  end
endmodule